// File: doc/BRIEF.md
# Two-Event Classification Tracker

This block sits in the digital part of a powered-device front end. It watches four comparator flags that describe where the line voltage lies: above the mark-reset level, above the lower class threshold, above the upper class threshold, and above the undervoltage lockout level. From these flags it follows the sequence the power source steps through, and it decides whether the source ran a two-event (type 2) hardware classification. The expected sequence is a class window, a drop back into the mark range, a second class window, and then a rise past the upper class threshold.

The tracker drives four outputs. One enables the detection signature and one enables the classification current. A third enables the low-resistance mark signature. The fourth is an active-low type-2 indicator, which the powered load reads once the pass switch has finished inrush. A thermal-shutdown flag, an inrush-active flag and a disable request are also inputs, and each of them can gate the outputs. The comparator flags are asynchronous to the clock, so they pass through a two-stage synchronizer before the logic uses them. All input-to-output timing in this document is counted from the synchronized flags.

Top module: `tc2_tracker`

## Requirements
- R1: After reset and whenever the voltage is below the lower class threshold (`cls_lo_i`=0), `det_sig_en_o` is 1. Above that threshold it is 0. Comparator flags take effect two clock edges after they change.
- R2: `cls_cur_en_o` is 1 only when the voltage is inside the class window (`cls_lo_i`=1, `cls_hi_i`=0), `therm_sd_i`=0 and `dis_req_i`=0. It is 0 above the upper class threshold, during thermal shutdown, and while the disable request is set.
- R3: `mark_sig_en_o` goes to 1 at the first drop from the class window into the mark range (`mark_rst_i`=1, `cls_lo_i`=0). It stays at 1 at every voltage above the mark-reset level, including operation. It clears only when `mark_rst_i`=0.
- R4: A type-2 result is latched when the voltage rises past the upper class threshold after a class, mark, class sequence. The result survives operation and any fall that stays above the mark-reset level.
- R5: A voltage below the mark-reset level (`mark_rst_i`=0) returns the tracker to its start state. This clears both the latched type-2 result and the mark signature.
- R6: If the sequence is broken anywhere else, no type-2 result is produced until the next mark reset. This covers a jump past the upper class threshold before the second class window, and a second drop into the mark range. The state encoding is one-hot, and any invalid code recovers to the start state.
- R7: `type2_n_o` is 0 only when a type-2 result is latched, `uvlo_ok_i`=1, `inrush_i`=0 and `therm_sd_i`=0. In every other case it is 1.
- R8: A single-class path leaves `type2_n_o` at 1 throughout operation. A single-class path is one class window followed directly by the rise to the operating level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mark_rst_i | input | 1 | Voltage above mark-reset level |
| cls_lo_i | input | 1 | Voltage above lower class threshold |
| cls_hi_i | input | 1 | Voltage above upper class threshold |
| uvlo_ok_i | input | 1 | Voltage above undervoltage lockout level |
| therm_sd_i | input | 1 | Thermal shutdown active |
| inrush_i | input | 1 | Pass switch in inrush limiting |
| dis_req_i | input | 1 | Disable request from the enable pin |
| det_sig_en_o | output | 1 | Detection signature enable |
| mark_sig_en_o | output | 1 | Mark signature enable |
| cls_cur_en_o | output | 1 | Classification current enable |
| type2_n_o | output | 1 | Type-2 indicator, active low |

## Verification
The assertions assume the four voltage flags are nested. That is, UVLO implies upper, upper implies lower, and lower implies mark-reset. They also assume all four flags move together, as one voltage would make them. The bench keeps to this by drawing only a voltage region number and deriving every flag from it. It holds each region for several clocks so the synchronizer and the state register settle before the outputs are sampled. The random walk mostly moves one region at a time, with occasional multi-region jumps to exercise the broken-path transitions.

// File: rtl/tc2_pkg.sv
package tc2_pkg;
  localparam int NUM_FLAGS = 4;
  localparam int FL_MR  = 0;
  localparam int FL_LO  = 1;
  localparam int FL_HI  = 2;
  localparam int FL_UV  = 3;

  localparam int NUM_ST  = 6;
  localparam int ST_IDLE = 0;
  localparam int ST_CLS1 = 1;
  localparam int ST_MRK1 = 2;
  localparam int ST_CLS2 = 3;
  localparam int ST_T2   = 4;
  localparam int ST_BRK  = 5;

  typedef logic [NUM_ST-1:0]    state_t;
  typedef logic [NUM_FLAGS-1:0] flags_t;
endpackage

// File: rtl/tc2_sync.sv
module tc2_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '0;
        else        pipe[s] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '0;
        else        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/tc2_fsm.sv
module tc2_fsm
  import tc2_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  flags_t flags_i,
  output state_t st_o,
  output logic   mark_o
);
  state_t st_q, st_d;
  logic   mark_q, mark_d;
  logic   st_en, mark_en;
  logic   mr, in_win, above, in_mark;

  assign mr      = flags_i[FL_MR];
  assign in_win  = flags_i[FL_LO] & ~flags_i[FL_HI];
  assign above   = flags_i[FL_HI];
  assign in_mark = mr & ~flags_i[FL_LO];

  always_comb begin
    st_d = '0;
    if (!mr || $countones(st_q) != 1) begin
      st_d[ST_IDLE] = 1'b1;
    end else if (st_q[ST_IDLE]) begin
      if (above)       st_d[ST_BRK]  = 1'b1;
      else if (in_win) st_d[ST_CLS1] = 1'b1;
      else             st_d[ST_IDLE] = 1'b1;
    end else if (st_q[ST_CLS1]) begin
      if (above)        st_d[ST_BRK]  = 1'b1;
      else if (in_mark) st_d[ST_MRK1] = 1'b1;
      else              st_d[ST_CLS1] = 1'b1;
    end else if (st_q[ST_MRK1]) begin
      if (above)       st_d[ST_BRK]  = 1'b1;
      else if (in_win) st_d[ST_CLS2] = 1'b1;
      else             st_d[ST_MRK1] = 1'b1;
    end else if (st_q[ST_CLS2]) begin
      if (above)        st_d[ST_T2]   = 1'b1;
      else if (in_mark) st_d[ST_BRK]  = 1'b1;
      else              st_d[ST_CLS2] = 1'b1;
    end else if (st_q[ST_T2]) begin
      st_d[ST_T2] = 1'b1;
    end else begin
      st_d[ST_BRK] = 1'b1;
    end
  end

  always_comb begin
    mark_d = mark_q;
    if (!mr)                           mark_d = 1'b0;
    else if (st_q[ST_CLS1] && in_mark) mark_d = 1'b1;
  end

  assign st_en   = (st_d != st_q);
  assign mark_en = (mark_d != mark_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= state_t'(1 << ST_IDLE);
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_q <= 1'b0;
    end else if (mark_en) begin
      mark_q <= mark_d;
    end
  end

  assign st_o   = st_q;
  assign mark_o = mark_q;
endmodule

// File: rtl/tc2_outs.sv
module tc2_outs
  import tc2_pkg::*;
(
  input  flags_t flags_i,
  input  state_t st_i,
  input  logic   mark_i,
  input  logic   therm_i,
  input  logic   inrush_i,
  input  logic   dis_i,
  output logic   det_en_o,
  output logic   mark_en_o,
  output logic   cls_en_o,
  output logic   type2_n_o
);
  logic win;
  logic t2_ok;

  assign win       = flags_i[FL_LO] & ~flags_i[FL_HI];
  assign t2_ok     = st_i[ST_T2] & flags_i[FL_UV] & ~inrush_i & ~therm_i;
  assign det_en_o  = ~flags_i[FL_LO];
  assign mark_en_o = mark_i;
  assign cls_en_o  = win & ~therm_i & ~dis_i;
  assign type2_n_o = ~t2_ok;
endmodule

// File: rtl/tc2_tracker.sv
module tc2_tracker
  import tc2_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mark_rst_i,
  input  logic cls_lo_i,
  input  logic cls_hi_i,
  input  logic uvlo_ok_i,
  input  logic therm_sd_i,
  input  logic inrush_i,
  input  logic dis_req_i,
  output logic det_sig_en_o,
  output logic mark_sig_en_o,
  output logic cls_cur_en_o,
  output logic type2_n_o
);
  logic [RST_STAGES-1:0] rst_pipe;
  logic   rst_int_n;
  flags_t flags_raw, flags_s;
  state_t st;
  logic   mark_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[RST_STAGES-1];

  assign flags_raw[FL_MR] = mark_rst_i;
  assign flags_raw[FL_LO] = cls_lo_i;
  assign flags_raw[FL_HI] = cls_hi_i;
  assign flags_raw[FL_UV] = uvlo_ok_i;

  tc2_sync #(.WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_int_n), .d_i(flags_raw), .q_o(flags_s)
  );

  tc2_fsm fsm_i (
    .clk(clk), .rst_n(rst_int_n), .flags_i(flags_s), .st_o(st), .mark_o(mark_q)
  );

  tc2_outs outs_i (
    .flags_i(flags_s), .st_i(st), .mark_i(mark_q),
    .therm_i(therm_sd_i), .inrush_i(inrush_i), .dis_i(dis_req_i),
    .det_en_o(det_sig_en_o), .mark_en_o(mark_sig_en_o),
    .cls_en_o(cls_cur_en_o), .type2_n_o(type2_n_o)
  );
endmodule

// File: rtl/tc2_tracker_chk.sv
module tc2_tracker_chk
  import tc2_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   cls_lo_i,
  input logic   cls_hi_i,
  input logic   therm_sd_i,
  input logic   inrush_i,
  input logic   dis_req_i,
  input logic   det_sig_en_o,
  input logic   mark_sig_en_o,
  input logic   cls_cur_en_o,
  input logic   type2_n_o,
  input flags_t flags_s,
  input state_t st
);
  logic [2:0] up_cnt;
  logic       ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           up_cnt <= '0;
    else if (up_cnt != 7) up_cnt <= up_cnt + 3'd1;
  end
  assign ok = (up_cnt >= 3'd6);

  AST_DET_TRACKS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> (det_sig_en_o == !$past(cls_lo_i, 2))) else $error("det"); // R1
  AST_CLS_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && cls_cur_en_o) |-> ($past(cls_lo_i, 2) && !$past(cls_hi_i, 2))) else $error("cls win"); // R2
  AST_CLS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    cls_cur_en_o |-> (!therm_sd_i && !dis_req_i)) else $error("cls gate"); // R2
  AST_MARK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && mark_sig_en_o && flags_s[FL_MR]) |=> mark_sig_en_o) else $error("mark"); // R3
  AST_T2_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && st[ST_T2] && flags_s[FL_MR]) |=> st[ST_T2]) else $error("t2 hold"); // R4
  AST_MR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && !flags_s[FL_MR]) |=> (st[ST_IDLE] && !mark_sig_en_o)) else $error("clear"); // R5
  AST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> ($countones(st) == 1)) else $error("onehot"); // R6
  AST_T2N_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !type2_n_o |-> (!inrush_i && !therm_sd_i && flags_s[FL_UV] && st[ST_T2])) else $error("t2n"); // R7
endmodule

bind tc2_tracker tc2_tracker_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cls_lo_i(cls_lo_i), .cls_hi_i(cls_hi_i),
  .therm_sd_i(therm_sd_i), .inrush_i(inrush_i), .dis_req_i(dis_req_i),
  .det_sig_en_o(det_sig_en_o), .mark_sig_en_o(mark_sig_en_o),
  .cls_cur_en_o(cls_cur_en_o), .type2_n_o(type2_n_o),
  .flags_s(flags_s), .st(st)
);

// File: tb/tc2_tracker_tb.sv
module tc2_tracker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mr = 0, lo = 0, hi = 0, uv = 0, th = 0, inr = 0, dis = 0;
  logic det, mark, cls, t2n;
  int   errors = 0;
  int   checks = 0;
  bit   done = 0;
  int   region = 0;
  int   mst = 0;     // 0 idle 1 cls1 2 mrk1 3 cls2 4 t2 5 broken
  bit   mmark = 0;

  always #2.5 clk = ~clk;

  tc2_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .mark_rst_i(mr), .cls_lo_i(lo), .cls_hi_i(hi),
    .uvlo_ok_i(uv), .therm_sd_i(th), .inrush_i(inr), .dis_req_i(dis),
    .det_sig_en_o(det), .mark_sig_en_o(mark), .cls_cur_en_o(cls), .type2_n_o(t2n)
  );

  function automatic int next_st(int s, int r);
    if (r == 0) return 0;
    case (s)
      0: return (r >= 3) ? 5 : (r == 2) ? 1 : 0;
      1: return (r >= 3) ? 5 : (r == 1) ? 2 : 1;
      2: return (r >= 3) ? 5 : (r == 2) ? 3 : 2;
      3: return (r >= 3) ? 4 : (r == 1) ? 5 : 3;
      4: return 4;
      default: return 5;
    endcase
  endfunction

  function automatic bit next_mark(int s, int r, bit m);
    if (r == 0) return 1'b0;
    if (s == 1 && r == 1) return 1'b1;
    return m;
  endfunction

  function automatic bit exp_cls(int r, bit t, bit d);
    return (r == 2) && !t && !d;
  endfunction

  function automatic bit exp_t2n(int s, int r, bit i, bit t);
    return !((s == 4) && (r == 4) && !i && !t);
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b (region %0d)", req, what, act, exp, region);
    end
  endtask

  task automatic step(int r, bit t, bit i, bit d);
    @(negedge clk);
    region = r;
    mr = (r >= 1); lo = (r >= 2); hi = (r >= 3); uv = (r >= 4);
    th = t; inr = i; dis = d;
    mmark = next_mark(mst, r, mmark);
    mst   = next_st(mst, r);
    repeat (6) @(negedge clk);
    chk("R1", "det_sig_en", det, (r < 2));
    chk("R2", "cls_cur_en", cls, exp_cls(r, t, d));
    chk("R3", "mark_sig_en", mark, mmark);
    chk("R7", "type2_n", t2n, exp_t2n(mst, r, i, t));
  endtask

  initial begin
    int r;
    void'($urandom(32'h5eed_2c1a));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state
    chk("R1", "reset det", det, 1'b1);
    chk("R3", "reset mark", mark, 1'b0);
    chk("R2", "reset cls", cls, 1'b0);
    chk("R7", "reset type2_n", t2n, 1'b1);

    // R4: full two-event path, with inrush then normal operation
    step(1,0,0,0); step(2,0,0,0); step(1,0,0,0);
    chk("R3", "mark after first drop", mark, 1'b1);
    step(2,0,0,0); step(3,0,0,0);
    step(4,0,1,0);
    chk("R7", "inrush keeps type2_n high", t2n, 1'b1);
    step(4,0,0,0);
    chk("R4", "type2 latched in operation", t2n, 1'b0);
    step(4,1,0,0);
    chk("R7", "thermal releases type2_n", t2n, 1'b1);
    step(4,0,0,0);
    // R4: survives a dip that stays above mark reset
    step(1,0,0,0); step(4,0,0,0);
    chk("R4", "latch survives dip", t2n, 1'b0);
    // R5: below mark reset clears
    step(0,0,0,0);
    chk("R5", "mark cleared", mark, 1'b0);
    step(4,0,0,0);
    chk("R5", "result cleared", t2n, 1'b1);
    step(0,0,0,0);

    // R8: single class straight to operation
    step(1,0,0,0); step(2,0,0,0); step(3,0,0,0); step(4,0,0,0);
    chk("R8", "single class type2_n", t2n, 1'b1);
    step(0,0,0,0);

    // R6: second drop into mark breaks the path
    step(2,0,0,0); step(1,0,0,0); step(2,0,0,0); step(1,0,0,0);
    step(2,0,0,0); step(4,0,0,0);
    chk("R6", "broken by extra mark", t2n, 1'b1);
    step(0,0,0,0);
    // R6: jump from mark straight above upper
    step(2,0,0,0); step(1,0,0,0); step(4,0,0,0);
    chk("R6", "broken by skip", t2n, 1'b1);
    step(0,0,0,0);

    // R2: window gating by thermal and disable
    step(2,0,0,1);
    chk("R2", "disable gates class", cls, 1'b0);
    step(2,1,0,0);
    step(2,0,0,0);
    chk("R2", "class on in window", cls, 1'b1);
    step(0,0,0,0);

    // random walk
    r = 0;
    for (int n = 0; n < 2500; n++) begin
      if ($urandom_range(9) == 0) r = $urandom_range(4);
      else if ($urandom_range(1) == 0) r = (r < 4) ? r + 1 : r - 1;
      else r = (r > 0) ? r - 1 : r + 1;
      step(r, ($urandom_range(7) == 0), ($urandom_range(3) == 0), ($urandom_range(7) == 0));
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule